// File: doc/BRIEF.md
# Dual-Channel Mode and Output Controller

This block sits at the digital output of a two-channel sampling converter. The two channels are called I and Q, and each runs on its own sample clock. A shared two-bit mode input chooses one of four operating arrangements. These are: both channels idle, I alone, both channels in step, or both channels with the Q result lagging by half a sample period. The mode input may change at any time without regard to either clock. Each channel therefore resynchronises it through a two-flop chain in its own clock domain before acting on it.

A running channel registers its raw sample on every rising edge. An idle channel keeps its last registered word on its outputs and always drives them to a known value. It never releases them to high impedance. A per-channel valid flag stays low until the channel has captured a fixed number of consecutive samples. This warm-up is 20 by default. It starts again after every reset and every return from idle. In the lagging arrangement the Q word and its valid flag are taken from a copy re-registered on the falling edge of the Q clock.

Top module: `dcc_top`

## Requirements
- R1: While reset is asserted and just after it is released, all four outputs are zero.
- R2: Mode 2'b00 idles both channels: neither data output changes and both valid flags are low.
- R3: Mode 2'b01 runs I, which captures `i_sample` on each rising edge of `i_clk`, and idles Q, which holds its data with its valid flag low.
- R4: Mode 2'b10 runs both channels, and each channel's captured word appears on its output straight after the rising edge that captured it.
- R5: Mode 2'b11 runs both channels, and the Q word and Q valid flag appear only after the next falling edge of `q_clk`, half a period later than in mode 2'b10.
- R6: An idle channel keeps the last word it captured and drives a known value on every output bit.
- R7: A valid flag goes high on the rising edge that makes the WARM_CYCLES-th (20th) consecutive capture of its channel, and it stays high while the channel keeps running.
- R8: A run shorter than WARM_CYCLES captures never raises valid, and the count starts again from zero after every idle period.
- R9: A change on `mode_sel` is first acted on at the third rising edge of a channel's clock after the change. Until then the old mode still governs capture.
- R10: After reset is released with a running mode already applied, warm-up behaves exactly as in R7 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | I channel sample clock |
| q_clk | input | 1 | Q channel sample clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mode_sel | input | 2 | Operating mode, asynchronous to both clocks |
| i_sample | input | DW | Raw I sample word |
| q_sample | input | DW | Raw Q sample word |
| i_data_o | output | DW | Registered I output word |
| i_valid_o | output | 1 | I output word is valid |
| q_data_o | output | DW | Registered (or half-cycle lagged) Q output word |
| q_valid_o | output | 1 | Q output word is valid |

## Verification
A mode change made between edges is first used for capture at the third rising edge that follows. The Q lag selector switches one edge earlier, because it comes from the same synchroniser output without the capture register. A valid flag rises on edge 22 after the change: two synchroniser edges, then twenty captures. The bench keeps a per-edge reference that uses the old mode for edges 1 and 2 and the new one from edge 3. It samples 2 ns after each rising edge and again 2 ns after the falling edge. At the early sample it expects the lagged Q output to show the previous word, and at the late sample the current one. Stimulus changes only at the late sample point, well away from both edges.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        MODE_ALL_IDLE   = 2'b00,
        MODE_I_ONLY     = 2'b01,
        MODE_PAIR_ALIGN = 2'b10,
        MODE_PAIR_LAG   = 2'b11
    } dcc_mode_e;

    function automatic logic mode_runs_i(input logic [1:0] m);
        return (dcc_mode_e'(m) != MODE_ALL_IDLE);
    endfunction

    function automatic logic mode_runs_q(input logic [1:0] m);
        return (dcc_mode_e'(m) == MODE_PAIR_ALIGN) || (dcc_mode_e'(m) == MODE_PAIR_LAG);
    endfunction

    function automatic logic mode_lags_q(input logic [1:0] m);
        return (dcc_mode_e'(m) == MODE_PAIR_LAG);
    endfunction

endpackage

// File: rtl/dcc_mode_sync.sv
module dcc_mode_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = async_i;
        end else begin : g_rest
            always_comb stage_d[g] = stage_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dcc_chan_core.sv
module dcc_chan_core #(
    parameter int DW   = 8,
    parameter int WARM = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [DW-1:0] raw_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o
);

    localparam int CW = $clog2(WARM + 1);
    localparam logic [CW-1:0] WARM_TOP = CW'(WARM);

    typedef struct packed {
        logic [DW-1:0] data;
        logic [CW-1:0] cnt;
        logic          valid;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            st_d.data = raw_i;
            if (st_q.cnt != WARM_TOP) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        st_d.valid = run_i && (st_d.cnt == WARM_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

    // Independent run-length counter for the warm-up check
    logic [CW:0] run_len_d, run_len_q;
    always_comb begin
        run_len_d = run_len_q;
        if (!run_i)                             run_len_d = '0;
        else if (run_len_q <= (CW+1)'(WARM))    run_len_d = run_len_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len_q <= '0;
        else        run_len_q <= run_len_d;
    end

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(data_o));

    p_idle_novalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !valid_o);

    p_valid_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(run_i));

    p_warm_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (run_len_q == (CW+1)'(WARM)));

endmodule

// File: rtl/dcc_half_lag.sv
module dcc_half_lag #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lag_sel_i,
    input  logic [DW-1:0] data_i,
    input  logic          valid_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } lag_st_t;

    lag_st_t lag_d, lag_q;

    always_comb begin
        lag_d.data  = data_i;
        lag_d.valid = valid_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) lag_q <= '0;
        else        lag_q <= lag_d;
    end

    assign data_o  = lag_sel_i ? lag_q.data  : data_i;
    assign valid_o = lag_sel_i ? lag_q.valid : valid_i;

    p_half_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_q.data == data_i) && (lag_q.valid == valid_i));

endmodule

// File: rtl/dcc_top.sv
module dcc_top #(
    parameter int DW          = 8,
    parameter int WARM_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic          i_clk,
    input  logic          q_clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic [DW-1:0] i_sample,
    input  logic [DW-1:0] q_sample,
    output logic [DW-1:0] i_data_o,
    output logic          i_valid_o,
    output logic [DW-1:0] q_data_o,
    output logic          q_valid_o
);

    import dcc_pkg::*;

    logic [1:0]    i_mode_sync, q_mode_sync;
    logic          i_run, q_run, q_lag;
    logic [DW-1:0] q_core_data;
    logic          q_core_valid;

    dcc_mode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_i_sync (
        .clk(i_clk), .rst_n(rst_n), .async_i(mode_sel), .sync_o(i_mode_sync)
    );

    dcc_mode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_q_sync (
        .clk(q_clk), .rst_n(rst_n), .async_i(mode_sel), .sync_o(q_mode_sync)
    );

    always_comb begin
        i_run = mode_runs_i(i_mode_sync);
        q_run = mode_runs_q(q_mode_sync);
        q_lag = mode_lags_q(q_mode_sync);
    end

    dcc_chan_core #(.DW(DW), .WARM(WARM_CYCLES)) u_i_core (
        .clk(i_clk), .rst_n(rst_n), .run_i(i_run), .raw_i(i_sample),
        .data_o(i_data_o), .valid_o(i_valid_o)
    );

    dcc_chan_core #(.DW(DW), .WARM(WARM_CYCLES)) u_q_core (
        .clk(q_clk), .rst_n(rst_n), .run_i(q_run), .raw_i(q_sample),
        .data_o(q_core_data), .valid_o(q_core_valid)
    );

    dcc_half_lag #(.DW(DW)) u_q_lag (
        .clk(q_clk), .rst_n(rst_n), .lag_sel_i(q_lag),
        .data_i(q_core_data), .valid_i(q_core_valid),
        .data_o(q_data_o), .valid_o(q_valid_o)
    );

endmodule

// File: tb/test_dcc_top.sv
module test_dcc_top;

    localparam int DW   = 8;
    localparam int WARM = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'b00;
    logic [DW-1:0] i_sample = '0, q_sample = '0;
    logic [DW-1:0] i_data_o, q_data_o;
    logic          i_valid_o, q_valid_o;

    always #4 clk = ~clk;   // 125 MHz

    dcc_top #(.DW(DW), .WARM_CYCLES(WARM), .SYNC_STAGES(2)) i_dcc_top (
        .i_clk(clk), .q_clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .i_sample(i_sample), .q_sample(q_sample),
        .i_data_o(i_data_o), .i_valid_o(i_valid_o),
        .q_data_o(q_data_o), .q_valid_o(q_valid_o)
    );

    int n_cmp = 0, n_bad = 0, gcyc = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] exp_i, qd_now, qd_prev;
    logic          vi, qv_now, qv_prev;
    int            cnt_i, cnt_q;
    bit            run_i_prev, run_q_prev, lag_prev;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] steps;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 8'd8},  '{2'b10, 8'd25}, '{2'b00, 8'd8},  '{2'b01, 8'd25},
        '{2'b11, 8'd26}, '{2'b10, 8'd6},  '{2'b00, 8'd8},  '{2'b01, 8'd10},
        '{2'b00, 8'd6},  '{2'b11, 8'd25}, '{2'b10, 8'd25}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic model_reset();
        exp_i = '0; qd_now = '0; qd_prev = '0;
        vi = 0; qv_now = 0; qv_prev = 0;
        cnt_i = 0; cnt_q = 0;
        run_i_prev = 0; run_q_prev = 0; lag_prev = 0;
    endtask

    // Entered at a point 6 ns after a rising edge (2 ns after the falling edge).
    task automatic run_vec(input logic [1:0] m, input int steps, input string vreq);
        bit ri = (m != 2'b00);
        bit rq = m[1];
        bit lg = (m == 2'b11);
        mode_sel = m;
        for (int k = 1; k <= steps; k++) begin
            bit cap_i = (k >= 3) ? ri : run_i_prev;
            bit cap_q = (k >= 3) ? rq : run_q_prev;
            bit sel   = (k >= 2) ? lg : lag_prev;
            string rq_s = (k < 3) ? "R9" : mode_req(m);
            gcyc++;
            i_sample = DW'(gcyc * 37 + 5);
            q_sample = DW'(gcyc * 11) ^ 8'hA5;
            if (cap_i) begin exp_i = i_sample; cnt_i = (cnt_i < WARM) ? cnt_i + 1 : WARM; end
            else cnt_i = 0;
            vi = (cnt_i >= WARM);
            qd_prev = qd_now; qv_prev = qv_now;
            if (cap_q) begin qd_now = q_sample; cnt_q = (cnt_q < WARM) ? cnt_q + 1 : WARM; end
            else cnt_q = 0;
            qv_now = (cnt_q >= WARM);
            @(posedge clk);
            #2;
            chk(rq_s, "i_data", 32'(i_data_o), 32'(exp_i));
            chk({vreq, "/R7/R8"}, "i_valid", 32'(i_valid_o), 32'(vi));
            chk(rq_s, "q_data early", 32'(q_data_o), sel ? 32'(qd_prev) : 32'(qd_now));
            chk({vreq, "/R7/R8"}, "q_valid early", 32'(q_valid_o), sel ? 32'(qv_prev) : 32'(qv_now));
            if (!cap_i) chk("R6", "i_data known", 32'($isunknown(i_data_o)), 32'(0));
            if (!cap_q) chk("R6", "q_data known", 32'($isunknown(q_data_o)), 32'(0));
            #4;
            chk("R5", "q_data late", 32'(q_data_o), 32'(qd_now));
            chk("R5", "q_valid late", 32'(q_valid_o), 32'(qv_now));
        end
        run_i_prev = ri; run_q_prev = rq; lag_prev = lg;
    endtask

    initial begin
        model_reset();
        #30;
        chk("R1", "i_data in reset", 32'(i_data_o), 32'(0));
        chk("R1", "i_valid in reset", 32'(i_valid_o), 32'(0));
        chk("R1", "q_data in reset", 32'(q_data_o), 32'(0));
        chk("R1", "q_valid in reset", 32'(q_valid_o), 32'(0));
        @(posedge clk); #6;
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1", "i_data after reset", 32'(i_data_o), 32'(0));
        chk("R1", "q_valid after reset", 32'(q_valid_o), 32'(0));
        #4;
        for (int v = 0; v < NVEC; v++)
            run_vec(VECS[v].mode, int'(VECS[v].steps), "R7");

        // Reset in the middle of a run, release straight into a running mode
        rst_n = 1'b0;
        #3;
        chk("R1", "i_data mid reset", 32'(i_data_o), 32'(0));
        chk("R1", "q_data mid reset", 32'(q_data_o), 32'(0));
        chk("R1", "i_valid mid reset", 32'(i_valid_o), 32'(0));
        model_reset();
        @(posedge clk); #6;
        rst_n = 1'b1;
        run_vec(2'b11, 24, "R10");
        run_vec(2'b01, 23, "R10");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule